// File: doc/BRIEF.md
# Two-Port Synchronous Static Memory with Strap-Selected Output Staging

This block is a 4096-word by 9-bit memory with two fully independent ports, called left and right. Each port has its own clock, synchronous reset, stall input, active-low select, write/read select, 12-bit address, 9-bit write data, asynchronous active-low output enable, 9-bit read data and a drive flag. The drive flag stands in for a tri-state bus: when it is low the port would be high-impedance, and the read data is forced to zero. The ninth data bit is left free for the user, typically for parity.

Address, data and control are captured on the rising edge of the port's own clock. The left port always returns read data one clock after the address is captured. A strap input chooses the right port's mode. In flow-through mode the word follows the captured address within the same cycle. In pipelined mode the right port matches the left. A port whose select is high at an edge powers down and stops driving. After such a deselect, a pipelined port must see two selected edges before it drives again. Each port runs a power state machine with three states:

- `PW_OFF` is powered down. A deselected edge or a reset moves the port here (transition *deselect*).
- `PW_WAKE` is the first selected edge after `PW_OFF` (transition *wake*).
- `PW_ON` is running normally. A second selected edge moves `PW_WAKE` here (transition *arm*), and further selected edges keep the port here (transition *stay*).

Top module: `dual_port_sync_ram`

## Requirements
- R1: A rising edge with select low (0) and write/read low (0) stores the write data at the address, for every address from 0 to 4095. A flow-through read of the same address captured at that same edge shows the new word.
- R2: On the left port, a read (select 0, write/read 1) captured at edge k, while the port is in `PW_ON`, drives the word with the drive flag at 1 from edge k+1 onward.
- R3: With the right strap at 0 (flow-through), a read captured at edge k drives the addressed word with the drive flag at 1 from edge k onward, in any power state.
- R4: With the right strap at 1, the right port follows the one-edge latency of R2.
- R5: Output enable high forces the drive flag to 0 and the read data to 0 at once, with no clock edge. Taking it low again restores the output.
- R6: With stall at 1 at an edge, no address, data or control is captured, no write takes place, and the port's output state and data do not change.
- R7: A pipelined port that captures a deselect at edge k does not drive after edge k+1. Two selected edges are then needed before a read can be captured that will drive, so the first word appears after the third selected edge.
- R8: A write captured at edge k leaves a pipelined port not driving after edge k+1.
- R9: A word written through one port is returned by a read of the same address on the other port.
- R10: When both ports write the same address at the same edge of a shared clock, the left port's word is stored.
- R11: Reset clears the output register and the drive flag and puts the port in `PW_OFF`. Memory contents survive reset.
- R12: While the drive flag is 0, the read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_l | input | 1 | Left port clock |
| rst_l | input | 1 | Left port synchronous reset, active high |
| stall_l | input | 1 | Left port stall: hold all registers |
| sel_n_l | input | 1 | Left port select, active low |
| wr_n_l | input | 1 | Left port 0 = write, 1 = read |
| addr_l | input | 12 | Left port address |
| din_l | input | 9 | Left port write data |
| oe_n_l | input | 1 | Left port output enable, active low, asynchronous |
| dout_l | output | 9 | Left port read data |
| drv_l | output | 1 | Left port output driven |
| clk_r | input | 1 | Right port clock |
| rst_r | input | 1 | Right port synchronous reset, active high |
| pipe_r | input | 1 | Right port strap: 1 = pipelined, 0 = flow-through |
| stall_r | input | 1 | Right port stall: hold all registers |
| sel_n_r | input | 1 | Right port select, active low |
| wr_n_r | input | 1 | Right port 0 = write, 1 = read |
| addr_r | input | 12 | Right port address |
| din_r | input | 9 | Right port write data |
| oe_n_r | input | 1 | Right port output enable, active low, asynchronous |
| dout_r | output | 9 | Right port read data |
| drv_r | output | 1 | Right port output driven |

## Verification
A power state machine stuck in the wrong state shows up at the drive flag within one or two edges. A port left in `PW_WAKE` never drives after a deselect. A port that skips `PW_WAKE` drives one edge too early after wake-up. Corruption in the split storage appears as a wrong word the first time the affected address is read on either port. An error in the same-address priority logic shows as the right port's word winning the collision. A stall that leaks shows as output data that changes during the held edge.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
    typedef enum logic [1:0] {
        PW_OFF  = 2'd0,
        PW_WAKE = 2'd1,
        PW_ON   = 2'd2
    } pwr_state_t;
endpackage

// File: rtl/dpr_bank.sv
module dpr_bank #(
    parameter int AW  = 12,
    parameter int DW  = 9,
    parameter int NRD = 3
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr [NRD],
    output logic [DW-1:0] rdata [NRD]
);
    timeunit 1ns; timeprecision 1ps;

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = mem[raddr[g]];
    end
endmodule

// File: rtl/dpr_port.sv
module dpr_port
    import dpr_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pipe,
    input  logic          stall,
    input  logic          sel_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic          oe_n,
    input  logic [DW-1:0] rd_data,
    output logic          wr_en,
    output logic [AW-1:0] rd_addr,
    output logic [DW-1:0] dout,
    output logic          drv
);
    timeunit 1ns; timeprecision 1ps;

    pwr_state_t    state_q, state_d;
    logic          rd_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] pdata_q;
    logic          pdrv_q;
    logic          drv_int;
    logic [DW-1:0] data_int;

    assign wr_en   = !rst && !stall && !sel_n && !wr_n;
    assign rd_addr = addr_q;

    always_comb begin
        if (sel_n) begin
            state_d = PW_OFF;
        end else begin
            unique case (state_q)
                PW_OFF:  state_d = PW_WAKE;
                PW_WAKE: state_d = PW_ON;
                PW_ON:   state_d = PW_ON;
                default: state_d = PW_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         state_q <= PW_OFF;
        else if (!stall) state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q    <= 1'b0;
            addr_q  <= '0;
            pdata_q <= '0;
            pdrv_q  <= 1'b0;
        end else if (!stall) begin
            rd_q    <= !sel_n && wr_n;
            addr_q  <= addr;
            pdata_q <= rd_data;
            pdrv_q  <= rd_q && (state_q == PW_ON);
        end
    end

    always_comb begin
        drv_int  = pipe ? pdrv_q : rd_q;
        data_int = pipe ? pdata_q : rd_data;
        drv      = drv_int && !oe_n;
        dout     = drv ? data_int : '0;
    end

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(pdrv_q) && $stable(pdata_q) && $stable(state_q)));

    // R7
    desel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && sel_n) ##1 !stall |=> !pdrv_q);

    // R8
    write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && !sel_n && !wr_n) ##1 !stall |=> !pdrv_q);

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!pdrv_q && !rd_q && state_q == PW_OFF));
endmodule

// File: rtl/dual_port_sync_ram.sv
module dual_port_sync_ram #(
    parameter int AW = 12,
    parameter int DW = 9
) (
    input  logic          clk_l,
    input  logic          rst_l,
    input  logic          stall_l,
    input  logic          sel_n_l,
    input  logic          wr_n_l,
    input  logic [AW-1:0] addr_l,
    input  logic [DW-1:0] din_l,
    input  logic          oe_n_l,
    output logic [DW-1:0] dout_l,
    output logic          drv_l,
    input  logic          clk_r,
    input  logic          rst_r,
    input  logic          pipe_r,
    input  logic          stall_r,
    input  logic          sel_n_r,
    input  logic          wr_n_r,
    input  logic [AW-1:0] addr_r,
    input  logic [DW-1:0] din_r,
    input  logic          oe_n_r,
    output logic [DW-1:0] dout_r,
    output logic          drv_r
);
    timeunit 1ns; timeprecision 1ps;

    localparam int NRD = 3;

    logic          wen_l, wen_r_raw, wen_r;
    logic [AW-1:0] ra_l, ra_r;
    logic [DW-1:0] rd_l, rd_r;
    logic [AW-1:0] bl_ra [NRD];
    logic [AW-1:0] br_ra [NRD];
    logic [DW-1:0] bl_rd [NRD];
    logic [DW-1:0] br_rd [NRD];

    dpr_port #(.AW(AW), .DW(DW)) u_port_l (
        .clk(clk_l), .rst(rst_l), .pipe(1'b1), .stall(stall_l),
        .sel_n(sel_n_l), .wr_n(wr_n_l), .addr(addr_l), .oe_n(oe_n_l),
        .rd_data(rd_l), .wr_en(wen_l), .rd_addr(ra_l),
        .dout(dout_l), .drv(drv_l)
    );

    dpr_port #(.AW(AW), .DW(DW)) u_port_r (
        .clk(clk_r), .rst(rst_r), .pipe(pipe_r), .stall(stall_r),
        .sel_n(sel_n_r), .wr_n(wr_n_r), .addr(addr_r), .oe_n(oe_n_r),
        .rd_data(rd_r), .wr_en(wen_r_raw), .rd_addr(ra_r),
        .dout(dout_r), .drv(drv_r)
    );

    // Same-edge, same-address write: the left port wins.
    assign wen_r = wen_r_raw && !(wen_l && (addr_l == addr_r));

    // Read slot 0 serves the other bank's write encoding, 1 and 2 serve the ports.
    assign bl_ra[0] = addr_r;
    assign bl_ra[1] = ra_l;
    assign bl_ra[2] = ra_r;
    assign br_ra[0] = addr_l;
    assign br_ra[1] = ra_l;
    assign br_ra[2] = ra_r;

    dpr_bank #(.AW(AW), .DW(DW), .NRD(NRD)) u_bank_l (
        .clk(clk_l), .we(wen_l), .waddr(addr_l),
        .wdata(din_l ^ br_rd[0]), .raddr(bl_ra), .rdata(bl_rd)
    );

    dpr_bank #(.AW(AW), .DW(DW), .NRD(NRD)) u_bank_r (
        .clk(clk_r), .we(wen_r), .waddr(addr_r),
        .wdata(din_r ^ bl_rd[0]), .raddr(br_ra), .rdata(br_rd)
    );

    assign rd_l = bl_rd[1] ^ br_rd[1];
    assign rd_r = bl_rd[2] ^ br_rd[2];
endmodule

// File: tb/tb_dual_port_sync_ram.sv
module tb_dual_port_sync_ram;
    timeunit 1ns; timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stall_l = 0, sel_n_l = 1, wr_n_l = 1, oe_n_l = 0;
    logic [11:0] addr_l = '0;
    logic [8:0]  din_l = '0;
    logic       pipe_r = 0, stall_r = 0, sel_n_r = 1, wr_n_r = 1, oe_n_r = 0;
    logic [11:0] addr_r = '0;
    logic [8:0]  din_r = '0;
    logic [8:0]  dout_l, dout_r;
    logic        drv_l, drv_r;
    int          n_tests = 0;
    int          n_fail = 0;

    always #2 clk = ~clk;

    dual_port_sync_ram dut (
        .clk_l(clk), .rst_l(rst), .stall_l(stall_l), .sel_n_l(sel_n_l),
        .wr_n_l(wr_n_l), .addr_l(addr_l), .din_l(din_l), .oe_n_l(oe_n_l),
        .dout_l(dout_l), .drv_l(drv_l),
        .clk_r(clk), .rst_r(rst), .pipe_r(pipe_r), .stall_r(stall_r),
        .sel_n_r(sel_n_r), .wr_n_r(wr_n_r), .addr_r(addr_r), .din_r(din_r),
        .oe_n_r(oe_n_r), .dout_r(dout_r), .drv_r(drv_r)
    );

    typedef struct packed {
        logic        sel_n;
        logic        wr_n;
        logic [11:0] addr;
        logic [8:0]  din;
        logic        edrv;
        logic [8:0]  edat;
    } vec_t;

    // Left port sequence from power-up; expectation sampled after each edge.
    localparam vec_t TBL [12] = '{
        '{1'b0, 1'b0, 12'd5, 9'h1A5, 1'b0, 9'h000},
        '{1'b0, 1'b0, 12'd6, 9'h05A, 1'b0, 9'h000},
        '{1'b0, 1'b1, 12'd5, 9'h000, 1'b0, 9'h000},
        '{1'b0, 1'b1, 12'd6, 9'h000, 1'b1, 9'h1A5},
        '{1'b1, 1'b1, 12'd0, 9'h000, 1'b1, 9'h05A},
        '{1'b0, 1'b1, 12'd5, 9'h000, 1'b0, 9'h000},
        '{1'b0, 1'b1, 12'd5, 9'h000, 1'b0, 9'h000},
        '{1'b0, 1'b1, 12'd6, 9'h000, 1'b1, 9'h1A5},
        '{1'b0, 1'b0, 12'd5, 9'h0FF, 1'b1, 9'h05A},
        '{1'b0, 1'b1, 12'd5, 9'h000, 1'b0, 9'h000},
        '{1'b0, 1'b1, 12'd6, 9'h000, 1'b1, 9'h0FF},
        '{1'b1, 1'b1, 12'd0, 9'h000, 1'b1, 9'h05A}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic lset(input logic s, input logic w, input logic [11:0] a, input logic [8:0] d);
        sel_n_l = s; wr_n_l = w; addr_l = a; din_l = d;
    endtask

    task automatic rset(input logic s, input logic w, input logic [11:0] a, input logic [8:0] d);
        sel_n_r = s; wr_n_r = w; addr_r = a; din_r = d;
    endtask

    task automatic chk(input string req, input logic gd, input logic ed,
                       input logic [8:0] gv, input logic [8:0] ev);
        n_tests++;
        if (gd !== ed || gv !== ev) begin
            n_fail++;
            $display("FAIL %s: drive=%0b data=%h, expected drive=%0b data=%h", req, gd, gv, ed, ev);
        end
    endtask

    initial begin
        #100us;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) tick();
        chk("R11 left after reset", drv_l, 1'b0, dout_l, 9'h000);
        chk("R11 R12 right after reset", drv_r, 1'b0, dout_r, 9'h000);
        rst = 1'b0;

        for (int i = 0; i < 12; i++) begin
            lset(TBL[i].sel_n, TBL[i].wr_n, TBL[i].addr, TBL[i].din);
            tick();
            chk($sformatf("R1 R2 R7 R8 vector %0d", i), drv_l, TBL[i].edrv, dout_l, TBL[i].edat);
        end
        lset(1, 1, 0, 0);

        // R3 flow-through, R9 cross-port
        rset(0, 1, 6, 0); tick();
        chk("R3 R9 right flow read 6", drv_r, 1'b1, dout_r, 9'h05A);
        rset(0, 1, 5, 0); tick();
        chk("R3 R9 right flow read 5", drv_r, 1'b1, dout_r, 9'h0FF);

        // R5 asynchronous output enable
        oe_n_r = 1'b1; #0.5;
        chk("R5 R12 oe off", drv_r, 1'b0, dout_r, 9'h000);
        oe_n_r = 1'b0; #0.5;
        chk("R5 oe on", drv_r, 1'b1, dout_r, 9'h0FF);

        // R6 right stall drops a write
        stall_r = 1'b1; rset(0, 0, 6, 9'h111); tick();
        chk("R6 right stalled output held", drv_r, 1'b1, dout_r, 9'h0FF);
        stall_r = 1'b0; rset(0, 1, 6, 0); tick();
        chk("R6 stalled write ignored", drv_r, 1'b1, dout_r, 9'h05A);

        // R6 left stall holds the pipeline
        lset(0, 1, 5, 0); tick();
        lset(0, 1, 5, 0); tick();
        chk("R7 left wake not driving", drv_l, 1'b0, dout_l, 9'h000);
        lset(0, 1, 6, 0); tick();
        chk("R2 left read after wake", drv_l, 1'b1, dout_l, 9'h0FF);
        stall_l = 1'b1; lset(0, 1, 5, 0); tick();
        chk("R6 left stalled output held", drv_l, 1'b1, dout_l, 9'h0FF);
        stall_l = 1'b0; lset(1, 1, 0, 0); tick();
        chk("R6 left resumes held address", drv_l, 1'b1, dout_l, 9'h05A);

        // R4 right pipelined, R7 wake, R8 write gap
        rset(1, 1, 0, 0); tick();
        pipe_r = 1'b1;
        rset(0, 1, 6, 0); tick();
        chk("R7 right pipe after deselect", drv_r, 1'b0, dout_r, 9'h000);
        rset(0, 1, 6, 0); tick();
        chk("R7 right pipe wake", drv_r, 1'b0, dout_r, 9'h000);
        rset(0, 1, 5, 0); tick();
        chk("R4 right pipe first word", drv_r, 1'b1, dout_r, 9'h05A);
        rset(0, 0, 7, 9'h0C3); tick();
        chk("R4 right pipe second word", drv_r, 1'b1, dout_r, 9'h0FF);
        rset(0, 1, 7, 0); tick();
        chk("R8 right pipe after write", drv_r, 1'b0, dout_r, 9'h000);
        rset(1, 1, 0, 0); tick();
        chk("R4 R1 right pipe written word", drv_r, 1'b1, dout_r, 9'h0C3);
        rset(1, 1, 0, 0); tick();
        chk("R7 right pipe deselected", drv_r, 1'b0, dout_r, 9'h000);

        // R10 same-edge collision
        pipe_r = 1'b0;
        lset(0, 0, 9, 9'h155); rset(0, 0, 9, 9'h0AA); tick();
        lset(1, 1, 0, 0); rset(0, 1, 9, 0); tick();
        chk("R10 left wins collision", drv_r, 1'b1, dout_r, 9'h155);

        // R1 top address, same-edge flow-through visibility
        lset(0, 0, 12'd4095, 9'h1FF); rset(0, 1, 12'd4095, 0); tick();
        chk("R1 R9 top address", drv_r, 1'b1, dout_r, 9'h1FF);
        lset(1, 1, 0, 0);

        // R11 reset keeps memory
        rset(0, 1, 9, 0); tick();
        rst = 1'b1; tick();
        chk("R11 right cleared by reset", drv_r, 1'b0, dout_r, 9'h000);
        chk("R11 left cleared by reset", drv_l, 1'b0, dout_l, 9'h000);
        rst = 1'b0; rset(0, 1, 9, 0); tick();
        chk("R11 memory kept", drv_r, 1'b1, dout_r, 9'h155);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule